// File: doc/BRIEF.md
# ULPI Transceiver Low-Power Entry Controller

This block is the transceiver-side sequencer that moves a ULPI-style PHY into its low-power state and back out of it. While the link owns the 8-bit data bus, the block decodes register-write transactions. It acknowledges each command with NXT, captures the data byte, and commits the write when the link raises STP. Two registers are held here: a control register with an active-low suspend-enable bit, and an interrupt enable mask.

A committed write that clears the suspend bit starts the entry handshake. The block turns the bus around by raising DIR. It lets the output clock run for a fixed minimum number of rising edges, and then drops its registered clock-run request. From that point the block is in low power. The data pins then carry the two single-ended line-state bits, passed through with no register, and an active-high interrupt flag. All other pins are driven low. A link STP during low power restarts the clock request and sets the suspend bit again. After a short settling count, DIR is released.

Top module: `ulpi_lpm_ctrl`

## Requirements
- R1: During and right after reset, dir_o, nxt_o, lp_o and data_oe_o are 0, clk_gate_n_o is 1 and data_o is 0. The suspend bit (control bit 6) resets to 1 and the interrupt mask resets to 0, so all sources are masked.
- R2: While DIR is low and no write is in progress, a byte on data_i whose top two bits are 2'b10 is a register-write command, and its low six bits are the address. nxt_o is high in each of the next two cycles. The byte present in the second of those cycles is the write data. The write commits in the first later cycle with stp_i high. Bytes with any other top-bit code produce no NXT.
- R3: A committed write to address 0x04 with bit 6 clear raises dir_o in the cycle after the STP cycle. A write to 0x04 with bit 6 set, or a write to any other address, leaves dir_o low.
- R4: clk_gate_n_o falls after the fifth rising edge seen with dir_o high, so it is first observed low five cycles after dir_o is first observed high.
- R5: lp_o rises in the same cycle that clk_gate_n_o falls, and lp_o is never high while clk_gate_n_o is high.
- R6: While lp_o is high, data_o[1:0] follow ls_i[1:0] combinationally, data_o[2] and data_o[7:4] are 0, and data_oe_o is 1.
- R7: While lp_o is high, data_o[3] equals the OR over i of irq_src_i[i] AND mask[i]. The mask is written at address 0x0D, and mask bit i set enables source i.
- R8: While dir_o is high and lp_o is low, data_o is all zeros.
- R9: stp_i high in a low-power cycle raises clk_gate_n_o and clears lp_o in the next cycle. dir_o stays high for two more cycles and then falls. The suspend bit is set to 1 again, and register writes are decoded again once dir_o is low.
- R10: Bus bytes and stp_i presented while dir_o is high and before low power is reached have no effect: no NXT is produced and the entry timing is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Transceiver clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| data_i | input | 8 | Bus byte driven by the link |
| stp_i | input | 1 | Link stop strobe |
| ls_i | input | 2 | Single-ended receiver line state |
| irq_src_i | input | 5 | Raw interrupt conditions |
| data_o | output | 8 | Bus byte driven by the transceiver |
| data_oe_o | output | 1 | Transceiver drives the bus |
| dir_o | output | 1 | Bus direction, high when the transceiver owns it |
| nxt_o | output | 1 | Byte acknowledge toward the link |
| clk_gate_n_o | output | 1 | Output clock run request, low to stop |
| lp_o | output | 1 | Low-power state indication |

## Verification
The assertions assume that the link follows the write handshake. The command byte stays on the bus through the first NXT cycle, the data byte is present in the second, and STP comes only after the data byte has been taken. The assertions also assume that the link raises STP during low power only to request wakeup. The stimulus drives every write through a single task that keeps this cycle order. Stray STP pulses and garbage bytes are placed only inside the turnaround window, where R10 requires them to be ignored.

// File: rtl/ulpi_lpm_pkg.sv
package ulpi_lpm_pkg;
  typedef enum logic [1:0] {RW_IDLE, RW_ACK, RW_DAT, RW_STP} rw_state_e;
  typedef enum logic [1:0] {SQ_RUN, SQ_TURN, SQ_LOW, SQ_WAKE} sq_state_e;
  localparam logic [1:0] CMD_REGW = 2'b10;
  typedef struct packed {
    logic [5:0] addr;
    logic [7:0] data;
  } reg_wr_t;
endpackage

// File: rtl/ulpi_reg_port.sv
module ulpi_reg_port
  import ulpi_lpm_pkg::*;
#(
  parameter int          IRQ_W     = 5,
  parameter logic [5:0]  CTRL_ADDR = 6'h04,
  parameter logic [5:0]  MASK_ADDR = 6'h0D,
  parameter int          SUSP_BIT  = 6,
  parameter logic [7:0]  CTRL_RST  = 8'h40
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_busy_i,
  input  logic [7:0]       data_i,
  input  logic             stp_i,
  input  logic             wake_i,
  output logic             nxt_o,
  output logic             enter_o,
  output logic [7:0]       ctrl_o,
  output logic [IRQ_W-1:0] irq_mask_o
);
  rw_state_e        st_q;
  reg_wr_t          wr_q;
  logic [7:0]       ctrl_q;
  logic [IRQ_W-1:0] mask_q;
  logic             cmd_seen, commit;

  assign cmd_seen = (st_q == RW_IDLE) && !bus_busy_i && (data_i[7:6] == CMD_REGW);
  assign commit   = (st_q == RW_STP) && stp_i;
  assign nxt_o    = (st_q == RW_ACK) || (st_q == RW_DAT);
  assign enter_o  = commit && (wr_q.addr == CTRL_ADDR) && !wr_q.data[SUSP_BIT];
  assign ctrl_o     = ctrl_q;
  assign irq_mask_o = mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= RW_IDLE;
      wr_q <= '0;
    end else begin
      unique case (st_q)
        RW_IDLE: if (cmd_seen) begin
          st_q    <= RW_ACK;
          wr_q.addr <= data_i[5:0];
        end
        RW_ACK:  st_q <= RW_DAT;
        RW_DAT: begin
          st_q      <= RW_STP;
          wr_q.data <= data_i;
        end
        RW_STP:  if (stp_i) st_q <= RW_IDLE;
        default: st_q <= RW_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RST;
      mask_q <= '0;
    end else begin
      if (commit && wr_q.addr == CTRL_ADDR) ctrl_q <= wr_q.data;
      if (commit && wr_q.addr == MASK_ADDR) mask_q <= wr_q.data[IRQ_W-1:0];
      if (wake_i) ctrl_q[SUSP_BIT] <= 1'b1;
    end
  end

  a_r2_cmd_gets_nxt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_seen |=> nxt_o);
  a_r9_susp_restored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_i |=> ctrl_q[SUSP_BIT]);
  a_r2_commit_needs_stp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enter_o |-> stp_i);
endmodule

// File: rtl/ulpi_lpm_seq.sv
module ulpi_lpm_seq
  import ulpi_lpm_pkg::*;
#(
  parameter int MIN_EDGES  = 5,
  parameter int WAKE_EDGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enter_i,
  input  logic stp_i,
  output logic dir_o,
  output logic clk_gate_n_o,
  output logic lp_o,
  output logic busy_o,
  output logic wake_o
);
  localparam int CNT_MAX = (MIN_EDGES > WAKE_EDGES) ? MIN_EDGES : WAKE_EDGES;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] ENT_LAST  = CNT_W'(MIN_EDGES - 1);
  localparam logic [CNT_W-1:0] WAKE_LAST = CNT_W'(WAKE_EDGES - 1);

  sq_state_e        st_q;
  logic [CNT_W-1:0] cnt_q;

  assign busy_o = (st_q != SQ_RUN);
  assign wake_o = (st_q == SQ_LOW) && stp_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= SQ_RUN;
      cnt_q        <= '0;
      dir_o        <= 1'b0;
      clk_gate_n_o <= 1'b1;
      lp_o         <= 1'b0;
    end else begin
      unique case (st_q)
        SQ_RUN: if (enter_i) begin
          st_q  <= SQ_TURN;
          dir_o <= 1'b1;
          cnt_q <= '0;
        end
        SQ_TURN: begin
          if (cnt_q == ENT_LAST) begin
            st_q         <= SQ_LOW;
            clk_gate_n_o <= 1'b0;
            lp_o         <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        SQ_LOW: if (stp_i) begin
          st_q         <= SQ_WAKE;
          clk_gate_n_o <= 1'b1;
          lp_o         <= 1'b0;
          cnt_q        <= '0;
        end
        SQ_WAKE: begin
          if (cnt_q == WAKE_LAST) begin
            st_q  <= SQ_RUN;
            dir_o <= 1'b0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= SQ_RUN;
      endcase
    end
  end

  a_r5_lp_needs_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lp_o |-> !clk_gate_n_o && dir_o);
  a_r9_clock_before_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dir_o) |-> clk_gate_n_o && $past(clk_gate_n_o));
  a_r9_wake_restarts_clock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> clk_gate_n_o && !lp_o);
endmodule

// File: rtl/ulpi_lp_map.sv
module ulpi_lp_map #(
  parameter int IRQ_W = 5
) (
  input  logic             lp_i,
  input  logic [1:0]       ls_i,
  input  logic [IRQ_W-1:0] irq_src_i,
  input  logic [IRQ_W-1:0] irq_mask_i,
  output logic [7:0]       data_o
);
  logic irq;

  assign irq    = |(irq_src_i & irq_mask_i);
  // no register: line state reaches the pins while the clock is stopped
  assign data_o = lp_i ? {4'b0000, irq, 1'b0, ls_i} : 8'h00;
endmodule

// File: rtl/ulpi_lpm_ctrl.sv
module ulpi_lpm_ctrl #(
  parameter int         IRQ_W      = 5,
  parameter int         MIN_EDGES  = 5,
  parameter int         WAKE_EDGES = 2,
  parameter logic [5:0] CTRL_ADDR  = 6'h04,
  parameter logic [5:0] MASK_ADDR  = 6'h0D,
  parameter int         SUSP_BIT   = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       data_i,
  input  logic             stp_i,
  input  logic [1:0]       ls_i,
  input  logic [IRQ_W-1:0] irq_src_i,
  output logic [7:0]       data_o,
  output logic             data_oe_o,
  output logic             dir_o,
  output logic             nxt_o,
  output logic             clk_gate_n_o,
  output logic             lp_o
);
  localparam logic [7:0] CTRL_RST = 8'(1) << SUSP_BIT;
  localparam int         DC_W     = $clog2(MIN_EDGES + 1);

  logic             busy, wake, enter;
  logic [7:0]       ctrl;
  logic [IRQ_W-1:0] mask;

  ulpi_reg_port #(
    .IRQ_W(IRQ_W), .CTRL_ADDR(CTRL_ADDR), .MASK_ADDR(MASK_ADDR),
    .SUSP_BIT(SUSP_BIT), .CTRL_RST(CTRL_RST)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .bus_busy_i(busy), .data_i(data_i),
    .stp_i(stp_i), .wake_i(wake), .nxt_o(nxt_o), .enter_o(enter),
    .ctrl_o(ctrl), .irq_mask_o(mask)
  );

  ulpi_lpm_seq #(.MIN_EDGES(MIN_EDGES), .WAKE_EDGES(WAKE_EDGES)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .enter_i(enter), .stp_i(stp_i),
    .dir_o(dir_o), .clk_gate_n_o(clk_gate_n_o), .lp_o(lp_o),
    .busy_o(busy), .wake_o(wake)
  );

  ulpi_lp_map #(.IRQ_W(IRQ_W)) u_map (
    .lp_i(lp_o), .ls_i(ls_i), .irq_src_i(irq_src_i), .irq_mask_i(mask),
    .data_o(data_o)
  );

  assign data_oe_o = dir_o;

  // checker: edges seen with DIR high, saturating
  logic [DC_W-1:0] dir_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            dir_cnt_q <= '0;
    else if (!dir_o)                        dir_cnt_q <= '0;
    else if (dir_cnt_q != DC_W'(MIN_EDGES)) dir_cnt_q <= dir_cnt_q + 1'b1;
  end

  a_r4_min_edges: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(clk_gate_n_o) |-> dir_cnt_q >= DC_W'(MIN_EDGES));
  a_r3_dir_after_stp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dir_o) |-> $past(stp_i));
  a_r2_nxt_link_owned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nxt_o |-> !dir_o);
  a_r6_lp_pins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lp_o |-> data_o[1:0] == ls_i && !data_o[2] && data_o[7:4] == 4'h0 && data_oe_o);
  a_r7_no_src_no_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lp_o && irq_src_i == '0) |-> !data_o[3]);
  a_r8_turn_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_o && !lp_o) |-> data_o == 8'h00);
  a_r1_ctrl_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dir_o |-> clk_gate_n_o && !lp_o);
endmodule

// File: tb/ulpi_lpm_ctrl_test.sv
module ulpi_lpm_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] data_i = '0;
  logic       stp_i = 1'b0;
  logic [1:0] ls_i = '0;
  logic [4:0] irq_src_i = '0;
  logic [7:0] data_o;
  logic       data_oe_o, dir_o, nxt_o, clk_gate_n_o, lp_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ulpi_lpm_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .data_i(data_i), .stp_i(stp_i), .ls_i(ls_i),
    .irq_src_i(irq_src_i), .data_o(data_o), .data_oe_o(data_oe_o), .dir_o(dir_o),
    .nxt_o(nxt_o), .clk_gate_n_o(clk_gate_n_o), .lp_o(lp_o)
  );

  // behavioural reference
  int         m_ph, m_mode, m_n;
  logic [5:0] m_ad;
  logic [7:0] m_dv, m_ctrl;
  logic [4:0] m_mask;
  bit         e_dir, e_gate, e_lp;

  always @(posedge clk or negedge rst_ni) begin
    bit busy, enter;
    if (!rst_ni) begin
      m_ph = 0; m_mode = 0; m_n = 0; m_ad = 0; m_dv = 0;
      m_ctrl = 8'h40; m_mask = 0; e_dir = 0; e_gate = 1; e_lp = 0;
    end else begin
      busy  = (m_mode != 0);
      enter = 0;
      case (m_ph)
        0: if (!busy && data_i[7:6] == 2'b10) begin m_ad = data_i[5:0]; m_ph = 1; end
        1: m_ph = 2;
        2: begin m_dv = data_i; m_ph = 3; end
        default: if (stp_i) begin
          if (m_ad == 6'h04) m_ctrl = m_dv;
          if (m_ad == 6'h0D) m_mask = m_dv[4:0];
          enter = (m_ad == 6'h04) && !m_dv[6];
          m_ph = 0;
        end
      endcase
      case (m_mode)
        0: if (enter) begin m_mode = 1; e_dir = 1; m_n = 0; end
        1: begin m_n++; if (m_n == 5) begin m_mode = 2; e_gate = 0; e_lp = 1; end end
        2: if (stp_i) begin m_mode = 3; e_gate = 1; e_lp = 0; m_ctrl[6] = 1; m_n = 0; end
        default: begin m_n++; if (m_n == 2) begin m_mode = 0; e_dir = 0; end end
      endcase
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic compare();
    logic [7:0] e_data;
    e_data = e_lp ? {4'b0, |(irq_src_i & m_mask), 1'b0, ls_i} : 8'h00;
    chk("R2 nxt_o", 8'(nxt_o), 8'(m_ph == 1 || m_ph == 2));
    chk("R3/R9/R10 dir_o", 8'(dir_o), 8'(e_dir));
    chk("R4/R9 clk_gate_n_o", 8'(clk_gate_n_o), 8'(e_gate));
    chk("R5 lp_o", 8'(lp_o), 8'(e_lp));
    chk("R6 data_oe_o", 8'(data_oe_o), 8'(e_dir));
    chk(e_lp ? "R6/R7 data_o" : "R8 data_o", data_o, e_data);
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
    end
  endtask

  task automatic reg_write(input logic [5:0] ad, input logic [7:0] val);
    data_i = {2'b10, ad};
    step(); step();
    data_i = val;
    step();
    data_i = 8'h00; stp_i = 1'b1;
    step();
    stp_i = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 dir_o", 8'(dir_o), 8'h00);
    chk("R1 nxt_o", 8'(nxt_o), 8'h00);
    chk("R1 clk_gate_n_o", 8'(clk_gate_n_o), 8'h01);
    chk("R1 lp_o", 8'(lp_o), 8'h00);
    chk("R1 data_o", data_o, 8'h00);
    rst_ni = 1'b1;
    step(2);
    reg_write(6'h0D, 8'h05);           // R7 mask: enable sources 0 and 2
    step();
    data_i = 8'hC5; step();            // R2: non-write codes give no NXT
    data_i = 8'h41; step();
    data_i = 8'h00; step(2);
    reg_write(6'h04, 8'h41);           // R3: suspend bit still set
    step(3);
    reg_write(6'h05, 8'h00);           // R3: other address
    step(3);
    reg_write(6'h04, 8'h00);           // R3: entry
    step();
    stp_i = 1'b1; data_i = 8'h84;      // R10: ignored during turnaround
    step();
    stp_i = 1'b0; data_i = 8'h00;
    step(6);
    for (int v = 0; v < 4; v++) begin  // R6: line state passes through
      ls_i = 2'(v); step();
    end
    irq_src_i = 5'b00010; step();      // R7: masked source
    irq_src_i = 5'b00100; step();      // R7: enabled source
    irq_src_i = 5'b00001; ls_i = 2'b01; step();
    irq_src_i = 5'b00000; step();
    stp_i = 1'b1; step();              // R9: wakeup
    stp_i = 1'b0; step(4);
    reg_write(6'h0D, 8'h1F);           // R9: decode works again
    reg_write(6'h04, 8'h00);
    step(7);
    irq_src_i = 5'b10000; ls_i = 2'b10; step(2);
    irq_src_i = 5'b00000; stp_i = 1'b1; step();
    stp_i = 1'b0; step(4);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule